// File: doc/BRIEF.md
# Gated Frequency Counter Sequencer

This block measures the rate of an unrelated input signal by counting its rising edges over a fixed window of system-clock time. A chain of BCD decade stages is clocked directly by the input signal. A control state machine in the system-clock domain runs the measurement in order: it opens a counting window, closes it, waits for the counter to settle, captures the digits, and then clears the counter.

The window enable is carried into the input-signal domain through a two-flop synchronizer. As a result, the counter keeps reacting for two more input edges after the window closes. The settle interval must therefore cover two input periods plus the synchronizer. The digits are read in the system domain only after that interval, so no multi-bit value is sampled while it changes. A divide-by-ten prescaler can be switched in ahead of the first decade for fast inputs. The prescale select is quasi-static: change it only while the sequencer is idle.

The digits and an overflow flag are presented in a held output register, with a one-cycle valid strobe for each result. States and transitions:
- IDLE goes to GATE on `start`.
- GATE goes to SETTLE after `GATE_CYCLES` cycles.
- SETTLE goes to LATCH after `SETTLE_CYCLES` cycles.
- LATCH goes to REPORT after `CAP_CYCLES` cycles.
- REPORT goes to CLEAR after one cycle.
- CLEAR goes to GATE when `cont` is high, otherwise to IDLE.

Top module: `fcnt_top`

## Requirements
- R1: With the prescaler bypassed, the result equals the number of `sig_in` rising edges that occur while the window is open, and the window stays open for exactly `GATE_CYCLES` system cycles.
- R2: The capture enable is never high while the window is open. It rises only after the window has been closed for at least `SETTLE_CYCLES` system cycles.
- R3: `digits` is BCD, with digit i held in bits [4i+3:4i] and digit 0 least significant. Each decade wraps from 9 to 0 and carries one into the next decade.
- R4: The output register follows the counter only while the capture enable is high, for `CAP_CYCLES` cycles. At all other times it holds its value.
- R5: When `pre_on` is 1, the decades count one step for every ten gated input edges. When `pre_on` is 0, they count every gated edge.
- R6: `ovf` is 1 in a result if the top decade wrapped during that window. It is 0 in the next result that does not wrap.
- R7: `valid` is high for exactly one cycle per result, after the capture ends, and the counter clear follows in the next cycle.
- R8: `start` begins a measurement only in IDLE. A `start` during a measurement has no effect.
- R9: With `cont` high, a new window opens right after each clear. When `cont` drops, the sequencer returns to IDLE after the current result.
- R10: A synchronous active-high `rst` returns the sequencer to IDLE, clears the counter, and sets `digits`, `ovf` and `valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Signal under measurement, clocks the decades |
| start | input | 1 | Begins one measurement when idle |
| cont | input | 1 | Continuous measurement mode |
| pre_on | input | 1 | Inserts the divide-by-ten prescaler |
| digits | output | 4*DIGITS | Held BCD result, digit 0 least significant |
| ovf | output | 1 | Top decade wrapped in this result |
| valid | output | 1 | One-cycle strobe per new result |

## Verification
A timer or state that is off by one shows up in the very next result. The count moves by the input rate for each extra or missing window cycle, or a capture arrives before the counter has stopped. A counter clear that is missed or arrives late shows up as residue added to the following result, and a wrong decade carry or prescaler phase corrupts the digits of that result. A sequencer that does not go back to IDLE shows up as an unexpected extra `valid` within one measurement period.

// File: rtl/fcnt_pkg.sv
package fcnt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_GATE,
        S_SETTLE,
        S_LATCH,
        S_REPORT,
        S_CLEAR
    } fcnt_state_t;

    localparam int BCD_W   = 4;
    localparam int PRE_DIV = 10;
endpackage

// File: rtl/fcnt_seq.sv
module fcnt_seq
    import fcnt_pkg::*;
#(
    parameter int GATE_CYCLES   = 100_000_000,
    parameter int SETTLE_CYCLES = 35,
    parameter int CAP_CYCLES    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cont,
    output logic gate_o,
    output logic lat_o,
    output logic valid_o,
    output logic clr_o
);
    localparam int TW = $clog2(GATE_CYCLES + 1);

    fcnt_state_t state, nxt;
    logic [TW-1:0] tmr;

    function automatic logic at_end(input logic [TW-1:0] t, input int len);
        return t == TW'(len - 1);
    endfunction

    // state register and dwell timer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            tmr   <= '0;
        end else begin
            state <= nxt;
            tmr   <= (state != nxt) ? '0 : tmr + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_GATE;
            S_GATE:   if (at_end(tmr, GATE_CYCLES)) nxt = S_SETTLE;
            S_SETTLE: if (at_end(tmr, SETTLE_CYCLES)) nxt = S_LATCH;
            S_LATCH:  if (at_end(tmr, CAP_CYCLES)) nxt = S_REPORT;
            S_REPORT: nxt = S_CLEAR;
            S_CLEAR:  nxt = cont ? S_GATE : S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o  <= 1'b0;
            lat_o   <= 1'b0;
            valid_o <= 1'b0;
            clr_o   <= 1'b1;
        end else begin
            gate_o  <= (nxt == S_GATE);
            lat_o   <= (nxt == S_LATCH);
            valid_o <= (nxt == S_REPORT);
            clr_o   <= (nxt == S_CLEAR);
        end
    end
endmodule

// File: rtl/fcnt_sync2.sv
module fcnt_sync2 (
    input  logic dst_clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge dst_clk or posedge clr) begin
        if (clr) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/fcnt_chain.sv
module fcnt_chain
    import fcnt_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic                  sig_clk,
    input  logic                  clr,
    input  logic                  en,
    input  logic                  pre_on,
    output logic [DIGITS*BCD_W-1:0] dig,
    output logic                  ovf
);
    localparam int PW = $clog2(PRE_DIV);

    logic [PW-1:0]   pre_cnt;
    logic            pre_wrap;
    logic [DIGITS:0] carry;

    assign pre_wrap = (pre_cnt == PW'(PRE_DIV - 1));

    always_ff @(posedge sig_clk or posedge clr) begin
        if (clr)
            pre_cnt <= '0;
        else if (en && pre_on)
            pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
    end

    assign carry[0] = en && (!pre_on || pre_wrap);

    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
        logic [BCD_W-1:0] d;
        logic             top;

        assign top          = (d == BCD_W'(9));
        assign carry[i+1]   = carry[i] && top;
        assign dig[i*BCD_W +: BCD_W] = d;

        always_ff @(posedge sig_clk or posedge clr) begin
            if (clr)
                d <= '0;
            else if (carry[i])
                d <= top ? '0 : d + 1'b1;
        end
    end

    // sticky wrap of the most significant decade
    always_ff @(posedge sig_clk or posedge clr) begin
        if (clr)
            ovf <= 1'b0;
        else if (carry[DIGITS])
            ovf <= 1'b1;
    end
endmodule

// File: rtl/fcnt_capture.sv
module fcnt_capture #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/fcnt_top.sv
module fcnt_top
    import fcnt_pkg::*;
#(
    parameter int DIGITS        = 8,
    parameter int GATE_CYCLES   = 100_000_000,
    parameter int SETTLE_CYCLES = 35,
    parameter int CAP_CYCLES    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sig_in,
    input  logic                    start,
    input  logic                    cont,
    input  logic                    pre_on,
    output logic [DIGITS*BCD_W-1:0] digits,
    output logic                    ovf,
    output logic                    valid
);
    localparam int DW = DIGITS * BCD_W;

    logic          gate_s, lat_en, clr_s, gate_x;
    logic [DW-1:0] raw_dig;
    logic          raw_ovf;

    fcnt_seq #(
        .GATE_CYCLES  (GATE_CYCLES),
        .SETTLE_CYCLES(SETTLE_CYCLES),
        .CAP_CYCLES   (CAP_CYCLES)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cont   (cont),
        .gate_o (gate_s),
        .lat_o  (lat_en),
        .valid_o(valid),
        .clr_o  (clr_s)
    );

    fcnt_sync2 u_sync (
        .dst_clk(sig_in),
        .clr    (clr_s),
        .d      (gate_s),
        .q      (gate_x)
    );

    fcnt_chain #(.DIGITS(DIGITS)) u_chain (
        .sig_clk(sig_in),
        .clr    (clr_s),
        .en     (gate_x),
        .pre_on (pre_on),
        .dig    (raw_dig),
        .ovf    (raw_ovf)
    );

    fcnt_capture #(.W(DW + 1)) u_cap (
        .clk(clk),
        .rst(rst),
        .en (lat_en),
        .d  ({raw_ovf, raw_dig}),
        .q  ({ovf, digits})
    );
endmodule

// File: rtl/fcnt_chk.sv
module fcnt_chk #(
    parameter int SETTLE_CYCLES = 35,
    parameter int DW            = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          gate,
    input logic          lat_en,
    input logic          valid,
    input logic          clr,
    input logic [DW-1:0] dout
);
    int since_fall;

    always_ff @(posedge clk) begin
        if (rst || gate)
            since_fall <= 0;
        else if (since_fall <= SETTLE_CYCLES)
            since_fall <= since_fall + 1;
    end

    p_gate_lat_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(gate && lat_en));

    p_settle_wait_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(lat_en) |-> (since_fall >= SETTLE_CYCLES));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(lat_en) |-> $stable(dout));

    p_valid_after_cap_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($past(lat_en) && !lat_en));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    p_clear_follows_r7: assert property (@(posedge clk) disable iff (rst)
        valid |=> clr);
endmodule

bind fcnt_top fcnt_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .DW           (DW)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .gate  (gate_s),
    .lat_en(lat_en),
    .valid (valid),
    .clr   (clr_s),
    .dout  (digits)
);

// File: tb/fcnt_top_tb.sv
module fcnt_top_tb;
    localparam int ND   = 2;
    localparam int GATE = 240;
    localparam int DWB  = ND * 4;

    logic clk = 1'b0, rst = 1'b1, sig = 1'b0;
    logic start = 1'b0, cont = 1'b0, pre_on = 1'b0;
    logic [DWB-1:0] digits;
    logic ovf, valid;

    int sig_per = 24;
    int n_chk = 0, n_bad = 0;
    logic [DWB:0] expq[$];
    string tagq[$];

    fcnt_top #(
        .DIGITS(ND), .GATE_CYCLES(GATE), .SETTLE_CYCLES(16), .CAP_CYCLES(4)
    ) u_dut (
        .clk(clk), .rst(rst), .sig_in(sig), .start(start), .cont(cont),
        .pre_on(pre_on), .digits(digits), .ovf(ovf), .valid(valid)
    );

    // 125 MHz: rising edges at 4 + 8n ns
    always #4 clk = ~clk;

    // input edges at 1 mod 8 ns, never coincident with clk edges
    initial begin
        #1 sig = 1'b1;
        forever begin
            #(sig_per / 2) sig = 1'b0;
            #(sig_per / 2) sig = 1'b1;
        end
    end

    function automatic logic [DWB:0] expect_of(input int n);
        logic [DWB:0] r;
        int v;
        v = n;
        r = '0;
        for (int i = 0; i < ND; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        r[DWB] = (v > 0);
        return r;
    endfunction

    task automatic check(input string tag, input logic [DWB:0] act, input logic [DWB:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got ovf=%0b digits=%h expected ovf=%0b digits=%h",
                     tag, act[DWB], act[DWB-1:0], exp[DWB], exp[DWB-1:0]);
        end
    endtask

    // monitor: pop one expected item per valid strobe
    always @(negedge clk) begin
        if (!rst && valid) begin
            if (expq.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R8/R9: unexpected valid, got digits=%h expected none", digits);
            end else begin
                check(tagq.pop_front(), {ovf, digits}, expq.pop_front());
            end
        end
    end

    task automatic push(input int per, input bit pre, input string tag);
        int raw;
        raw = GATE * 8 / per;
        expq.push_back(expect_of(pre ? raw / 10 : raw));
        tagq.push_back(tag);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 3000 && expq.size() != 0; i++) @(negedge clk);
        if (expq.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7: result missing, got none expected %0d", expq.size());
            expq.delete();
            tagq.delete();
        end
    endtask

    task automatic measure(input int per, input bit pre, input string tag);
        sig_per = per;
        pre_on  = pre;
        repeat (12) @(negedge clk);
        push(per, pre, tag);
        pulse_start();
        wait_empty();
        @(negedge clk);
        n_chk++;
        if (valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R7: valid wide, got %0b expected 0", valid);
        end
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset state", {ovf, digits}, '0);
        n_chk++;
        if (valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: valid got %0b expected 0", valid);
        end

        measure(24, 1'b0, "R1 per24 count80");
        measure(40, 1'b0, "R3 per40 count48");
        measure(48, 1'b0, "R1 per48 count40");
        measure(8,  1'b0, "R6 per8 wrap to 40 with ovf");
        measure(16, 1'b0, "R3 per16 wrap to 20 with ovf");
        measure(40, 1'b0, "R6 ovf cleared in next result");

        // R4: output holds long after capture while counter is cleared
        repeat (40) @(negedge clk);
        check("R4 held after capture", {ovf, digits}, expect_of(48));

        measure(8,  1'b1, "R5 prescale per8 count24");
        measure(24, 1'b1, "R5 prescale per24 count8");

        // R8: extra start mid-window is ignored
        sig_per = 24;
        pre_on  = 1'b0;
        repeat (12) @(negedge clk);
        push(24, 1'b0, "R8 start during gate ignored");
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        wait_empty();
        repeat (400) @(negedge clk);

        // R9: continuous mode, two back-to-back results then stop
        sig_per = 40;
        repeat (12) @(negedge clk);
        cont = 1'b1;
        push(40, 1'b0, "R9 continuous first");
        push(40, 1'b0, "R9 continuous second");
        pulse_start();
        for (int i = 0; i < 3000 && expq.size() > 1; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        cont = 1'b0;
        wait_empty();
        repeat (600) @(negedge clk);

        // R10: reset in the middle of a window clears everything
        sig_per = 16;
        repeat (12) @(negedge clk);
        pulse_start();
        repeat (100) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset mid-window", {ovf, digits}, '0);
        measure(24, 1'b0, "R10 clean count after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule